// File: doc/BRIEF.md
# Quadrature Encoder Input Conditioner

This block sits between the three raw encoder pins (phase A, phase B and index) and a quadrature decoder. Each pin first passes through a two-flop synchronizer. It can then be inverted and gated off, each pin under its own control. Finally it goes through a digital glitch filter that rejects pulses shorter than three sample periods.

The filter does not sample on every clock. It samples on a one-cycle tick from a free-running power-of-two prescaler, so the filter's time constant can be stretched from 3 to 384 system clocks. A bypass control skips the filter. The block also gives a one-cycle strobe on each rising edge of the conditioned index signal.

Top module: `quad_in_cond`

## Requirements
- R1: A raw input passes through two synchronizer flops and one output flop. With the filter bypassed, a level driven before clock edge n appears on the output after edge n+2.
- R2: Bit 0, bit 1 and bit 2 of `ch_inv_i` invert phase A, phase B and index, one bit each. The inversion is applied after synchronization.
- R3: Bit 0, bit 1 and bit 2 of `ch_en_i` enable phase A, phase B and index. A channel whose bit is 0 is forced to logic 0 after inversion, so its output settles at 0.
- R4: With `filt_bypass_i` = 1, each output register loads the conditioned (synchronized, inverted, gated) value on every clock.
- R5: With `filt_bypass_i` = 0, an output changes only on a sample tick. It takes a new level only when that level was seen on three consecutive ticks, counting the current one.
- R6: Code s on `div_sel_i` (0 to 7) sets a sample tick on clock edges where a free-running edge count since reset is a multiple of 2^s. The count is 0 at the first edge after reset.
- R7: `idx_rise_o` is high for exactly one cycle after the index output goes from 0 to 1, whether the filter is used or bypassed.
- R8: While `rst_ni` is low, all outputs are 0 and the filter history holds 0.
- R9: A pulse seen on fewer than three consecutive ticks never reaches the filtered output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raw_a_i | input | 1 | Raw phase A pin |
| raw_b_i | input | 1 | Raw phase B pin |
| raw_idx_i | input | 1 | Raw index pin |
| div_sel_i | input | 3 | Sample prescaler code, divide by 2^code |
| filt_bypass_i | input | 1 | 1 = skip the glitch filter |
| ch_en_i | input | 3 | Channel enables {idx, B, A} |
| ch_inv_i | input | 3 | Channel inversions {idx, B, A} |
| a_o | output | 1 | Conditioned phase A |
| b_o | output | 1 | Conditioned phase B |
| idx_o | output | 1 | Conditioned index |
| idx_rise_o | output | 1 | One-cycle strobe on index rising edge |

## Verification
The hardest case to reach is a pulse that spans exactly two sample ticks at a large divide ratio. Such a pulse must be dropped, while one cycle more of width, landing on a third tick, must pass. Tick positions depend on the prescaler phase since reset. So the stimulus sweeps pulse widths both at fixed multiples of the period and at random hold lengths near 2 to 3 periods, under codes 1, 3, 5 and 7. A behavioural model tracks the runs of agreeing samples and decides every outcome.

// File: rtl/qc_pkg.sv
package qc_pkg;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned SYNC_STG = 2;
  localparam int unsigned FILT_LEN = 3;

  typedef enum logic [1:0] {
    CH_A   = 2'd0,
    CH_B   = 2'd1,
    CH_IDX = 2'd2
  } ch_e;
endpackage

// File: rtl/qc_prescaler.sv
module qc_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // 1<<7 wraps to 0 in CNT_W bits, so mask becomes all ones
  assign mask   = (CNT_W'(1) << div_sel_i) - CNT_W'(1);
  assign tick_o = ((cnt_q & mask) == '0);
endmodule

// File: rtl/qc_sync.sv
module qc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/qc_filter.sv
module qc_filter #(
  parameter int unsigned LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bypass_i,
  input  logic d_i,
  output logic q_o
);
  logic [LEN-2:0] hist_q;
  logic [LEN-1:0] win;
  logic           out_q;

  assign win = {hist_q, d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      out_q  <= 1'b0;
    end else begin
      if (tick_i) hist_q <= win[LEN-2:0];
      if (bypass_i)                    out_q <= d_i;
      else if (tick_i && (&win))       out_q <= 1'b1;
      else if (tick_i && !(|win))      out_q <= 1'b0;
    end
  end

  assign q_o = out_q;

  // R5
  filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && !tick_i) |=> $stable(out_q));

  // R4
  byp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> (out_q == $past(d_i)));
endmodule

// File: rtl/quad_in_cond.sv
module quad_in_cond
  import qc_pkg::*;
#(
  parameter int unsigned SEL_W    = qc_pkg::SEL_W,
  parameter int unsigned SYNC_STG = qc_pkg::SYNC_STG,
  parameter int unsigned FILT_LEN = qc_pkg::FILT_LEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_a_i,
  input  logic             raw_b_i,
  input  logic             raw_idx_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             filt_bypass_i,
  input  logic [2:0]       ch_en_i,
  input  logic [2:0]       ch_inv_i,
  output logic             a_o,
  output logic             b_o,
  output logic             idx_o,
  output logic             idx_rise_o
);
  logic [NUM_CH-1:0] raw, synced, cond, clean;
  logic              tick;
  logic              idx_prev_q;

  assign raw = {raw_idx_i, raw_b_i, raw_a_i};

  qc_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_sel_i(div_sel_i),
    .tick_o   (tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qc_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[c]),
      .q_o   (synced[c])
    );

    assign cond[c] = ch_en_i[c] & (synced[c] ^ ch_inv_i[c]);

    qc_filter #(.LEN(FILT_LEN)) u_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .bypass_i(filt_bypass_i),
      .d_i     (cond[c]),
      .q_o     (clean[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_prev_q <= 1'b0;
    else         idx_prev_q <= clean[CH_IDX];
  end

  assign a_o        = clean[CH_A];
  assign b_o        = clean[CH_B];
  assign idx_o      = clean[CH_IDX];
  assign idx_rise_o = clean[CH_IDX] & ~idx_prev_q;

  // R7
  rise_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_rise_o |=> !idx_rise_o);

  // R3
  dis_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ch_en_i[0] && filt_bypass_i) |=> !a_o);

  // R8
  rst_out_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !(a_o || b_o || idx_o || idx_rise_o));
endmodule

// File: tb/quad_in_cond_tb.sv
`timescale 1ns/1ps
module quad_in_cond_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ra = 1'b0, rb = 1'b0, ri = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       byp = 1'b1;
  logic [2:0] en = 3'b111, inv = 3'b000;
  logic       a_o, b_o, idx_o, rise_o;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R8";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  quad_in_cond u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .raw_a_i(ra), .raw_b_i(rb), .raw_idx_i(ri),
    .div_sel_i(sel), .filt_bypass_i(byp),
    .ch_en_i(en), .ch_inv_i(inv),
    .a_o(a_o), .b_o(b_o), .idx_o(idx_o), .idx_rise_o(rise_o)
  );

  // behavioural reference
  logic [2:0] dq[$];
  int         edges;
  logic [2:0] m_out;
  logic       m_rise;
  int         run[3];
  logic       last[3];

  task automatic model_reset();
    dq = {3'b000, 3'b000};
    edges = 0; m_out = '0; m_rise = 1'b0;
    for (int c = 0; c < 3; c++) begin run[c] = 2; last[c] = 1'b0; end
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      logic [2:0] s2, cond;
      logic       tick, prev;
      s2   = dq[0];
      cond = (s2 ^ inv) & en;
      tick = ((edges % (1 << sel)) == 0);
      prev = m_out[2];
      for (int c = 0; c < 3; c++) begin
        if (tick) begin
          if (cond[c] == last[c]) run[c]++;
          else begin last[c] = cond[c]; run[c] = 1; end
        end
        if (byp) m_out[c] = cond[c];
        else if (tick && run[c] >= 3) m_out[c] = last[c];
      end
      m_rise = m_out[2] & ~prev;
      dq.push_back({ri, rb, ra});
      void'(dq.pop_front());
      edges++;
    end
  end

  task automatic cmp(string nm, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp("a_o", a_o, m_out[0]);
    cmp("b_o", b_o, m_out[1]);
    cmp("idx_o", idx_o, m_out[2]);
    cmp("idx_rise_o", rise_o, (cur_req == "R7" || 1) ? m_rise : 1'b0);
  end

  task automatic drive(logic [2:0] v, int n);
    {ri, rb, ra} = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic rnd(int reps, int maxhold);
    for (int k = 0; k < reps; k++) drive(3'($urandom), 1 + ($urandom % maxhold));
  endtask

  task automatic summary();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    // R8: outputs at 0 during reset
    cur_req = "R8";
    drive(3'b111, 5);
    rst_n = 1'b1;

    // R1 / R4: bypass latency and follow
    cur_req = "R1";
    drive(3'b001, 4); drive(3'b010, 4); drive(3'b100, 4); drive(3'b111, 4); drive(3'b000, 4);
    cur_req = "R4";
    rnd(200, 1);

    // R2: per-channel inversion
    cur_req = "R2";
    inv = 3'b101; rnd(80, 2);
    inv = 3'b010; rnd(80, 2);
    inv = 3'b000;

    // R3: enables
    cur_req = "R3";
    en = 3'b010; rnd(80, 2);
    en = 3'b000; rnd(40, 2);
    en = 3'b101; rnd(80, 2);
    en = 3'b111;

    // R5 / R9: filter at divide-by-1, pulse widths 1..5
    byp = 1'b0; sel = 3'd0;
    cur_req = "R9";
    for (int w = 1; w <= 5; w++) begin drive(3'b111, w); drive(3'b000, 8); end
    cur_req = "R5";
    rnd(300, 4);

    // R6: prescaler codes
    cur_req = "R6";
    for (int s = 1; s < 8; s += 2) begin
      int p;
      sel = 3'(s); p = 1 << s;
      drive(3'b111, 2 * p); drive(3'b000, 4 * p);
      drive(3'b111, 2 * p + 1); drive(3'b000, 4 * p);
      drive(3'b111, 3 * p); drive(3'b000, 4 * p);
      for (int k = 0; k < 12; k++) drive(3'($urandom), 2 * p + ($urandom % (p + 2)));
    end
    sel = 3'd2; rnd(60, 12);
    sel = 3'd4; rnd(40, 60);

    // R7: index rising strobe, filtered and bypassed
    cur_req = "R7";
    sel = 3'd1;
    for (int k = 0; k < 6; k++) begin drive(3'b100, 8 + k); drive(3'b000, 10); end
    byp = 1'b1;
    for (int k = 0; k < 6; k++) begin drive(3'b100, 1 + k); drive(3'b000, 1 + k); end
    inv = 3'b100; rnd(60, 3);
    inv = 3'b000;

    // R8: mid-run reset
    cur_req = "R8";
    byp = 1'b0; drive(3'b111, 20);
    @(posedge clk); #1 rst_n = 1'b0;
    drive(3'b111, 4);
    rst_n = 1'b1;
    cur_req = "R5";
    rnd(100, 5);

    summary();
  end
endmodule